// File: doc/BRIEF.md
# Two-Entry Process-Tagged Translation Buffer

This block caches recent virtual-to-physical page translations. It sits between address generation and the memory access. A requester presents a 32-bit virtual address, an access kind (instruction fetch, data load or data store) and the current process identifier. In the same cycle the block answers with exactly one of three results: a hit with the translated physical address, a miss, or a permission fault.

Pages are 4 KB, so the low 12 address bits pass through untranslated. The two entries are fully associative. Each entry holds a virtual page number, an owning process identifier, a physical page number, a writable flag, a referenced flag and a modified flag. A page table walker outside the block loads entries through a fill port. A flush input empties the buffer on a context switch.

On a miss the requester keeps its request steady until the walker supplies the translation. The request then hits in the cycle after the fill is written.

Top module: `tlb_top`

## Requirements
- R1: On a hit, `resp_paddr` equals the stored physical page number followed by `req_vaddr[11:0]`. Otherwise `resp_paddr` is zero.
- R2: An entry matches only when it is valid and both its virtual page number (`req_vaddr[31:12]`) and its process identifier equal the request's. The same page requested under another process identifier misses.
- R3: While `req_valid` is high, exactly one of `resp_hit`, `resp_miss` and `resp_fault` is high, combinationally in the same cycle. While `req_valid` is low, all three are low.
- R4: Access kinds are encoded 0 = fetch, 1 = load, 2 = store, with 3 treated as a load. A store that matches a non-writable entry gives `resp_fault`, not a hit, and leaves that entry's referenced and modified flags unchanged. A fetch or load to a non-writable entry hits.
- R5: On a hit, `hit_ref` shows the entry's referenced flag as it stood before this access. Every hit sets the flag from the next cycle on. A fill clears it.
- R6: On a hit, `hit_dirty` shows the entry's modified flag as it stood before this access. Only a store hit sets it. A fill clears it.
- R7: A request that misses and is held keeps missing until a matching fill is accepted. It hits in the first cycle after the fill's clock edge.
- R8: A fill writes the lowest-numbered invalid entry when one exists, leaving valid entries untouched.
- R9: When every entry is valid, a fill replaces the entry named by a replacement pointer. The pointer resets to 0 and advances by one, wrapping, after each such replacement.
- R10: `flush` makes every entry invalid from the next cycle on. A fill in the same cycle as a flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_pid | input | PID_W (8) | Requesting process identifier |
| resp_hit | output | 1 | Translation found and permitted |
| resp_miss | output | 1 | No matching entry |
| resp_fault | output | 1 | Store to a non-writable page |
| resp_paddr | output | PPN_W+12 (32) | Physical address on a hit |
| hit_ref | output | 1 | Referenced flag of the hit entry before this access |
| hit_dirty | output | 1 | Modified flag of the hit entry before this access |
| fill_valid | input | 1 | Fill request from the walker |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pid | input | PID_W (8) | Owning process identifier |
| fill_ppn | input | PPN_W (20) | Physical page number to install |
| fill_writable | input | 1 | 1 = read-write page, 0 = read-only page |
| flush | input | 1 | Invalidate all entries |

## Verification
The hit, miss and fault results and the physical address are combinational, so they are due in the same cycle as the request. The bench drives each request just after a falling edge and samples 2 ns later, before the next rising edge. Fills, flushes and flag updates take effect at the next rising edge. The bench therefore checks their effects with a fresh request in a later cycle. The referenced and modified flags appear only on `hit_ref` and `hit_dirty`, so each flag update is checked by repeating the access.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int OFF_W = 12;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    function automatic logic acc_writes(input logic [1:0] acc);
        return acc == ACC_STORE;
    endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int N     = 2,
    parameter int VPN_W = 20,
    parameter int PID_W = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]            ent_valid,
    input  logic [N-1:0][VPN_W-1:0] ent_vpn,
    input  logic [N-1:0][PID_W-1:0] ent_pid,
    input  logic [VPN_W-1:0]        look_vpn,
    input  logic [PID_W-1:0]        look_pid,
    output logic                    any_match,
    output logic [IDX_W-1:0]        match_idx
);
    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = ent_valid[g] && (ent_vpn[g] == look_vpn) && (ent_pid[g] == look_pid);
    end

    always_comb begin
        match_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) match_idx = IDX_W'(i);
        end
    end

    assign any_match = |match;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N = 2,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     ent_valid,
    input  logic             fill_take,
    output logic [IDX_W-1:0] victim
);
    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] free_idx;
    logic             has_free;

    always_comb begin
        free_idx = '0;
        has_free = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                free_idx = IDX_W'(i);
                has_free = 1'b1;
            end
        end
    end

    assign victim = has_free ? free_idx : rr_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= '0;
        end else if (fill_take && !has_free) begin
            rr_ptr <= (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_top.sv
module tlb_top
    import tlb_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PPN_W   = 20,
    parameter int PID_W   = 8,
    parameter int ENTRIES = 2,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PA_W   = PPN_W + OFF_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_acc,
    input  logic [PID_W-1:0] req_pid,
    output logic             resp_hit,
    output logic             resp_miss,
    output logic             resp_fault,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             hit_ref,
    output logic             hit_dirty,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PID_W-1:0] fill_pid,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_writable,
    input  logic             flush
);
    logic [ENTRIES-1:0]            e_valid;
    logic [ENTRIES-1:0][VPN_W-1:0] e_vpn;
    logic [ENTRIES-1:0][PID_W-1:0] e_pid;
    logic [ENTRIES-1:0][PPN_W-1:0] e_ppn;
    logic [ENTRIES-1:0]            e_wr;
    logic [ENTRIES-1:0]            e_ref;
    logic [ENTRIES-1:0]            e_dirty;

    logic             any_match;
    logic [IDX_W-1:0] match_idx;
    logic [IDX_W-1:0] victim;
    logic             fill_take;
    logic             is_store;
    logic             perm_bad;

    tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_cam (
        .ent_valid (e_valid),
        .ent_vpn   (e_vpn),
        .ent_pid   (e_pid),
        .look_vpn  (req_vaddr[VA_W-1:OFF_W]),
        .look_pid  (req_pid),
        .any_match (any_match),
        .match_idx (match_idx)
    );

    assign fill_take = fill_valid && !flush;

    tlb_victim #(.N(ENTRIES)) u_victim (
        .clk       (clk),
        .rst       (rst),
        .ent_valid (e_valid),
        .fill_take (fill_take),
        .victim    (victim)
    );

    assign is_store   = acc_writes(req_acc);
    assign perm_bad   = is_store && !e_wr[match_idx];
    assign resp_hit   = req_valid && any_match && !perm_bad;
    assign resp_fault = req_valid && any_match && perm_bad;
    assign resp_miss  = req_valid && !any_match;
    assign resp_paddr = resp_hit ? {e_ppn[match_idx], req_vaddr[OFF_W-1:0]} : '0;
    assign hit_ref    = resp_hit && e_ref[match_idx];
    assign hit_dirty  = resp_hit && e_dirty[match_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            e_valid <= '0;
            e_vpn   <= '0;
            e_pid   <= '0;
            e_ppn   <= '0;
            e_wr    <= '0;
            e_ref   <= '0;
            e_dirty <= '0;
        end else if (flush) begin
            e_valid <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (fill_take && victim == IDX_W'(i)) begin
                    e_valid[i] <= 1'b1;
                    e_vpn[i]   <= fill_vpn;
                    e_pid[i]   <= fill_pid;
                    e_ppn[i]   <= fill_ppn;
                    e_wr[i]    <= fill_writable;
                    e_ref[i]   <= 1'b0;
                    e_dirty[i] <= 1'b0;
                end else if (resp_hit && match_idx == IDX_W'(i)) begin
                    e_ref[i] <= 1'b1;
                    if (is_store) e_dirty[i] <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int PID_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic [1:0]      req_acc,
    input logic            resp_hit,
    input logic            resp_miss,
    input logic            resp_fault,
    input logic [PA_W-1:0] resp_paddr,
    input logic            hit_ref,
    input logic            hit_dirty,
    input logic            flush
);
    assert_one_result_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> $countones({resp_hit, resp_miss, resp_fault}) == 1);

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !(resp_hit || resp_miss || resp_fault));

    assert_offset_pass_R1: assert property (@(posedge clk) disable iff (rst)
        resp_hit |-> resp_paddr[11:0] == req_vaddr[11:0]);

    assert_fault_on_store_R4: assert property (@(posedge clk) disable iff (rst)
        resp_fault |-> req_acc == 2'd2);

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(flush) && req_valid) |-> (!resp_hit && !resp_fault));

    assert_dirty_implies_ref_R6: assert property (@(posedge clk) disable iff (rst)
        (resp_hit && hit_dirty) |-> hit_ref);
endmodule

bind tlb_top tlb_checker #(.VA_W(VA_W), .PA_W(PA_W), .PID_W(PID_W)) u_tlb_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .req_acc    (req_acc),
    .resp_hit   (resp_hit),
    .resp_miss  (resp_miss),
    .resp_fault (resp_fault),
    .resp_paddr (resp_paddr),
    .hit_ref    (hit_ref),
    .hit_dirty  (hit_dirty),
    .flush      (flush)
);

// File: tb/tb_tlb_top.sv
module tb_tlb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic [7:0]  req_pid = '0;
    logic        resp_hit, resp_miss, resp_fault, hit_ref, hit_dirty;
    logic [31:0] resp_paddr;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [7:0]  fill_pid = '0;
    logic [19:0] fill_ppn = '0;
    logic        fill_writable = 1'b0;
    logic        flush = 1'b0;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    tlb_top dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc), .req_pid(req_pid),
        .resp_hit(resp_hit), .resp_miss(resp_miss), .resp_fault(resp_fault),
        .resp_paddr(resp_paddr), .hit_ref(hit_ref), .hit_dirty(hit_dirty),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
        .fill_ppn(fill_ppn), .fill_writable(fill_writable), .flush(flush)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present a request, sample 2 ns after the falling edge, release after the rising edge.
    task automatic access(input logic [31:0] va, input logic [1:0] acc, input logic [7:0] pid,
                          input logic [2:0] exp_hmf, input logic [31:0] exp_pa,
                          input logic exp_ref, input logic exp_dirty, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_pid = pid;
        #2;
        check({tag, " hit/miss/fault"}, {29'd0, resp_hit, resp_miss, resp_fault}, {29'd0, exp_hmf});
        check({tag, " paddr"}, resp_paddr, exp_pa);
        check({tag, " ref"}, {31'd0, hit_ref}, {31'd0, exp_ref});
        check({tag, " dirty"}, {31'd0, hit_dirty}, {31'd0, exp_dirty});
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [7:0] pid, input logic [19:0] ppn,
                        input logic wr, input logic fl);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_pid = pid; fill_ppn = ppn;
        fill_writable = wr; flush = fl;
        @(posedge clk); #1;
        fill_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk); #1;
        flush = 1'b0;
    endtask

    localparam logic [2:0] HIT = 3'b100, MISS = 3'b010, FLT = 3'b001;

    task automatic t_reset();
        @(negedge clk); #2;
        check("R3 idle after reset", {29'd0, resp_hit, resp_miss, resp_fault}, 32'd0);
        access(32'h0000_0004, 2'd0, 8'd1, MISS, 32'd0, 1'b0, 1'b0, "R3 empty lookup");
    endtask

    task automatic t_miss_hold();
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h0000_0004; req_acc = 2'd0; req_pid = 8'd1;
        for (int i = 0; i < 3; i++) begin
            #2;
            check("R7 held miss", {31'd0, resp_miss}, 32'd1);
            @(negedge clk);
        end
        fill_valid = 1'b1; fill_vpn = 20'h00000; fill_pid = 8'd1; fill_ppn = 20'h00001; fill_writable = 1'b0;
        #2;
        check("R7 miss while fill pending", {31'd0, resp_miss}, 32'd1);
        @(posedge clk); #1;
        fill_valid = 1'b0;
        @(negedge clk); #2;
        check("R7 hit after fill", {31'd0, resp_hit}, 32'd1);
        check("R1 paddr after fill", resp_paddr, 32'h0000_1004);
        check("R5 fresh ref clear", {31'd0, hit_ref}, 32'd0);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic t_readonly();
        access(32'h0000_0008, 2'd0, 8'd1, HIT, 32'h0000_1008, 1'b1, 1'b0, "R5 ref set by hit");
        access(32'h0000_0010, 2'd2, 8'd1, FLT, 32'd0, 1'b0, 1'b0, "R4 store to read-only");
        access(32'h0000_0010, 2'd1, 8'd1, HIT, 32'h0000_1010, 1'b1, 1'b0, "R4 load read-only no dirty");
        access(32'h0000_0ABC, 2'd3, 8'd1, HIT, 32'h0000_1ABC, 1'b1, 1'b0, "R4 code 3 as load");
    endtask

    task automatic t_pid();
        access(32'h0000_0004, 2'd0, 8'd2, MISS, 32'd0, 1'b0, 1'b0, "R2 other process");
        access(32'h0000_5004, 2'd0, 8'd1, MISS, 32'd0, 1'b0, 1'b0, "R2 other page");
    endtask

    task automatic t_rw();
        fill(20'h00007, 8'd1, 20'h00002, 1'b1, 1'b0);
        access(32'h0000_7FFC, 2'd2, 8'd1, HIT, 32'h0000_2FFC, 1'b0, 1'b0, "R6 first store");
        access(32'h0000_7FF0, 2'd2, 8'd1, HIT, 32'h0000_2FF0, 1'b1, 1'b1, "R6 dirty after store");
        access(32'h0000_0004, 2'd0, 8'd1, HIT, 32'h0000_1004, 1'b1, 1'b0, "R8 fill used free entry");
    endtask

    task automatic t_replace();
        fill(20'h00002, 8'd1, 20'h00003, 1'b1, 1'b0);
        access(32'h0000_0004, 2'd0, 8'd1, MISS, 32'd0, 1'b0, 1'b0, "R9 entry0 replaced");
        access(32'h0000_7000, 2'd1, 8'd1, HIT, 32'h0000_2000, 1'b1, 1'b1, "R9 entry1 kept");
        access(32'h0000_2134, 2'd1, 8'd1, HIT, 32'h0000_3134, 1'b0, 1'b0, "R5 refill clears flags");
        fill(20'h00009, 8'd1, 20'h00004, 1'b0, 1'b0);
        access(32'h0000_7000, 2'd1, 8'd1, MISS, 32'd0, 1'b0, 1'b0, "R9 pointer advanced");
        access(32'h0000_2134, 2'd1, 8'd1, HIT, 32'h0000_3134, 1'b1, 1'b0, "R9 entry0 kept");
        access(32'h0000_9001, 2'd0, 8'd1, HIT, 32'h0000_4001, 1'b0, 1'b0, "R9 new entry");
        fill(20'h0000A, 8'd1, 20'h00005, 1'b0, 1'b0);
        access(32'h0000_2134, 2'd1, 8'd1, MISS, 32'd0, 1'b0, 1'b0, "R9 pointer wrapped");
    endtask

    task automatic t_flush();
        do_flush();
        access(32'h0000_9001, 2'd0, 8'd1, MISS, 32'd0, 1'b0, 1'b0, "R10 flushed a");
        access(32'h0000_A001, 2'd0, 8'd1, MISS, 32'd0, 1'b0, 1'b0, "R10 flushed b");
        fill(20'h0000B, 8'd1, 20'h00006, 1'b1, 1'b1);
        access(32'h0000_B000, 2'd0, 8'd1, MISS, 32'd0, 1'b0, 1'b0, "R10 flush beats fill");
        fill(20'h0000C, 8'd3, 20'h00007, 1'b1, 1'b0);
        fill(20'h0000D, 8'd3, 20'h00008, 1'b1, 1'b0);
        access(32'h0000_C123, 2'd2, 8'd3, HIT, 32'h0000_7123, 1'b0, 1'b0, "R8 first free slot");
        access(32'h0000_D123, 2'd2, 8'd3, HIT, 32'h0000_8123, 1'b0, 1'b0, "R8 second free slot");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_miss_hold();
        t_readonly();
        t_pid();
        t_rw();
        t_replace();
        t_flush();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule